// File: doc/BRIEF.md
# InfoFrame Packet Builder

This block turns one auxiliary video/audio info packet into the sequence of 32-bit register writes that a packet register bank expects. A client gives it the packet type, the version, the length and the payload body, then pulses a start request. The builder computes the packet checksum and places it in payload byte 0. It formats a header word and then walks the payload in 7-byte subpackets. Each subpacket goes out as a low word and a high word. One word leaves per clock on a valid/index/data write port.

The payload body enters as bytes 1 up to the maximum length, because byte 0 is always generated internally. When the type equals the configured audio type, only the first subpacket is written. The register bank pads the rest of that packet on its own. The checksum and the header still cover the full length.

Top module: `ifr_pkt_builder`

## Requirements
- R1: Payload byte 0 is written as the checksum: 0x00 minus the 8-bit wrapping sum of type, version, (length-1) and body bytes 1 to length-1.
- R2: The header word holds the type in bits [7:0], the version in bits [15:8], length-1 in bits [23:16] and zero in bits [31:24].
- R3: Subpacket k carries payload bytes 7k to 7k+6. Its low word holds bytes 7k..7k+3 with the lowest byte in bits [7:0]. Its high word holds bytes 7k+4..7k+6 in bits [23:0], and bits [31:24] are zero.
- R4: Any byte position at or beyond the length inside the last subpacket is written as 0x00.
- R5: The header is written to index base, the low word of subpacket k to base+1+2k, and the high word to base+2+2k.
- R6: When the type equals AUDIO_TYPE (default 0x84), exactly one subpacket is written, whatever the length.
- R7: A start request is accepted only while busy is low. busy is high in exactly the cycles in which a word is written, from the header to the last high word. A start request while busy has no effect on the words written.
- R8: Words leave one per clock with no gap, in this order: the header, then low and high for subpacket 0, 1, and so on.
- R9: For a non-audio packet of length L (1 to MAX_LEN), ceil(L/7) subpackets are written, for a total of 1+2*ceil(L/7) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| frm_type_i | input | 8 | Packet type |
| frm_ver_i | input | 8 | Packet version |
| frm_len_i | input | LW | Payload length in bytes, including the checksum byte |
| frm_body_i | input | (MAX_LEN-1)*8 | Payload bytes 1..MAX_LEN-1, byte 1 in the lowest 8 bits |
| base_idx_i | input | AW | Register index of the header word |
| busy_o | output | 1 | A packet is being written |
| wr_valid_o | output | 1 | A word is written this cycle |
| wr_index_o | output | AW | Register index of the word |
| wr_data_o | output | 32 | Word data |

## Verification
The bench uses the default MAX_LEN of 28 and AW of 8. With these values the longest packet spans four full subpackets, so every subpacket index and the final step of the index offset are reached. Lengths of 1, 7, 8, 14, 20 and 28 cover a lone checksum byte, exact subpacket boundaries and partial last subpackets with zero padding. Bodies of all 0xFF make the checksum sum wrap many times. An audio-type packet of length 11 shows the truncation to one subpacket, and a base index near the top of the 8-bit range shows the index arithmetic.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } ifr_state_e;
endpackage

// File: rtl/ifr_csum.sv
module ifr_csum #(
  parameter int MAX_LEN = 28,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic [7:0]               typ_i,
  input  logic [7:0]               ver_i,
  input  logic [LW-1:0]            len_i,
  input  logic [(MAX_LEN-1)*8-1:0] body_i,
  output logic [7:0]               csum_o
);
  logic [7:0] acc;

  always_comb begin
    acc = typ_i + ver_i + (8'(len_i) - 8'd1);
    for (int i = 1; i < MAX_LEN; i++) begin
      if (LW'(i) < len_i) begin
        acc = acc + body_i[(i-1)*8 +: 8];
      end
    end
    csum_o = 8'h00 - acc;
  end
endmodule

// File: rtl/ifr_subpack.sv
module ifr_subpack #(
  parameter int MAX_LEN = 28,
  parameter int NSP     = (MAX_LEN + 6) / 7,
  parameter int SW      = (NSP > 1) ? $clog2(NSP) : 1
) (
  input  logic [MAX_LEN*8-1:0] pay_i,
  input  logic [SW-1:0]        sp_i,
  input  logic                 hi_i,
  output logic [31:0]          word_o
);
  localparam int NB = NSP * 7;

  logic [7:0] pb [NB];
  logic [7:0] sb [7];

  for (genvar g = 0; g < NB; g++) begin : g_pad
    if (g < MAX_LEN) begin : g_real
      assign pb[g] = pay_i[g*8 +: 8];
    end else begin : g_zero
      assign pb[g] = 8'h00;
    end
  end

  always_comb begin
    for (int j = 0; j < 7; j++) begin
      sb[j] = pb[int'(sp_i) * 7 + j];
    end
    if (hi_i) begin
      word_o = {8'h00, sb[6], sb[5], sb[4]};
    end else begin
      word_o = {sb[3], sb[2], sb[1], sb[0]};
    end
  end
endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [SW-1:0]    last_i,
  input  logic             audio_i,
  output ifr_state_e       state_o,
  output logic [SW-1:0]    sp_o
);
  ifr_state_e state_q, state_d;
  logic [SW-1:0] sp_q, sp_d, last_q;
  logic          audio_q;

  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    case (state_q)
      ST_IDLE: if (go_i) begin
        state_d = ST_HDR;
        sp_d    = '0;
      end
      ST_HDR: state_d = ST_LO;
      ST_LO:  state_d = ST_HI;
      ST_HI: begin
        if (sp_q == last_q) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_LO;
          sp_d    = sp_q + SW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      audio_q <= 1'b0;
    end else if (go_i && state_q == ST_IDLE) begin
      last_q  <= last_i;
      audio_q <= audio_i;
    end
  end

  assign state_o = state_q;
  assign sp_o    = sp_q;

  // R6: an audio packet never advances beyond subpacket 0
  a_r6_audio_single: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_q && state_q != ST_IDLE) |-> (sp_q == '0));

  // R8: the last high word is followed by idle, a non-last one by the next low word
  a_r8_hi_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI && sp_q != last_q) |=> (state_q == ST_LO));
endmodule

// File: rtl/ifr_pkt_builder.sv
module ifr_pkt_builder
  import ifr_pkg::*;
#(
  parameter int       MAX_LEN    = 28,
  parameter int       AW         = 8,
  parameter bit [7:0] AUDIO_TYPE = 8'h84,
  parameter int       LW         = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [7:0]               frm_type_i,
  input  logic [7:0]               frm_ver_i,
  input  logic [LW-1:0]            frm_len_i,
  input  logic [(MAX_LEN-1)*8-1:0] frm_body_i,
  input  logic [AW-1:0]            base_idx_i,
  output logic                     busy_o,
  output logic                     wr_valid_o,
  output logic [AW-1:0]            wr_index_o,
  output logic [31:0]              wr_data_o
);
  localparam int NSP = (MAX_LEN + 6) / 7;
  localparam int SW  = (NSP > 1) ? $clog2(NSP) : 1;

  ifr_state_e state;
  logic [SW-1:0] sp;
  logic          go, is_audio;
  logic [7:0]    csum;
  logic [LW:0]   nsp_w;
  logic [SW-1:0] last_sp;
  logic [31:0]   sp_word;

  logic [7:0]           typ_q, ver_q;
  logic [LW-1:0]        len_q;
  logic [MAX_LEN*8-1:0] pay_q, pay_d;
  logic [AW-1:0]        base_q;

  assign go       = start_i && !busy_o;
  assign is_audio = (frm_type_i == AUDIO_TYPE);

  ifr_csum #(.MAX_LEN(MAX_LEN), .LW(LW)) u_csum (
    .typ_i (frm_type_i),
    .ver_i (frm_ver_i),
    .len_i (frm_len_i),
    .body_i(frm_body_i),
    .csum_o(csum)
  );

  always_comb begin
    nsp_w   = ({1'b0, frm_len_i} + (LW+1)'(6)) / (LW+1)'(7);
    last_sp = is_audio ? '0 : SW'(nsp_w - (LW+1)'(1));
    pay_d[7:0] = csum;
    for (int i = 1; i < MAX_LEN; i++) begin
      pay_d[i*8 +: 8] = (LW'(i) < frm_len_i) ? frm_body_i[(i-1)*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q  <= '0;
      ver_q  <= '0;
      len_q  <= '0;
      pay_q  <= '0;
      base_q <= '0;
    end else if (go) begin
      typ_q  <= frm_type_i;
      ver_q  <= frm_ver_i;
      len_q  <= frm_len_i;
      pay_q  <= pay_d;
      base_q <= base_idx_i;
    end
  end

  ifr_seq #(.SW(SW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .last_i (last_sp),
    .audio_i(is_audio),
    .state_o(state),
    .sp_o   (sp)
  );

  ifr_subpack #(.MAX_LEN(MAX_LEN), .NSP(NSP), .SW(SW)) u_pack (
    .pay_i (pay_q),
    .sp_i  (sp),
    .hi_i  (state == ST_HI),
    .word_o(sp_word)
  );

  always_comb begin
    busy_o     = (state != ST_IDLE);
    wr_valid_o = busy_o;
    case (state)
      ST_HDR: begin
        wr_index_o = base_q;
        wr_data_o  = {8'h00, 8'(len_q) - 8'd1, ver_q, typ_q};
      end
      ST_LO: begin
        wr_index_o = base_q + AW'(1) + (AW'(sp) << 1);
        wr_data_o  = sp_word;
      end
      ST_HI: begin
        wr_index_o = base_q + AW'(2) + (AW'(sp) << 1);
        wr_data_o  = sp_word;
      end
      default: begin
        wr_index_o = '0;
        wr_data_o  = '0;
      end
    endcase
  end

  // R3: the eighth byte of every subpacket goes out as zero
  a_r3_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HI) |-> (wr_data_o[31:24] == 8'h00));

  // R5: consecutive writes of one packet use consecutive indices
  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_index_o == $past(wr_index_o) + AW'(1)));

  // R7: a start request while busy leaves the captured packet untouched
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(typ_q) && $stable(pay_q) && $stable(base_q)));

  // R8: every packet opens with its header word
  a_r8_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (state == ST_HDR && wr_index_o == base_q));
endmodule

// File: tb/ifr_pkt_builder_tb.sv
module ifr_pkt_builder_tb_top;
  localparam int       MAX_LEN = 28;
  localparam int       AW      = 8;
  localparam int       LW      = $clog2(MAX_LEN + 1);
  localparam bit [7:0] AUD     = 8'h84;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start_i = 1'b0;
  logic [7:0]               frm_type_i = '0, frm_ver_i = '0;
  logic [LW-1:0]            frm_len_i = '0;
  logic [(MAX_LEN-1)*8-1:0] frm_body_i = '0;
  logic [AW-1:0]            base_idx_i = '0;
  logic                     busy_o, wr_valid_o;
  logic [AW-1:0]            wr_index_o;
  logic [31:0]              wr_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] body [MAX_LEN];
  logic [AW+31:0] exp_q [$];
  string cur_req = "R1";

  always #2 clk = ~clk;

  ifr_pkt_builder #(.MAX_LEN(MAX_LEN), .AW(AW), .AUDIO_TYPE(AUD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frm_type_i(frm_type_i),
    .frm_ver_i(frm_ver_i), .frm_len_i(frm_len_i), .frm_body_i(frm_body_i),
    .base_idx_i(base_idx_i), .busy_o(busy_o), .wr_valid_o(wr_valid_o),
    .wr_index_o(wr_index_o), .wr_data_o(wr_data_o)
  );

  // monitor: compare each written word with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && wr_valid_o && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s R8: unexpected write idx=%0h data=%08h expected none",
                 cur_req, wr_index_o, wr_data_o);
      end else begin
        logic [AW+31:0] e;
        e = exp_q.pop_front();
        if ({wr_index_o, wr_data_o} !== e) begin
          errors++;
          $display("FAIL %s R1-R5: idx/data %0h/%08h expected %0h/%08h",
                   cur_req, wr_index_o, wr_data_o, e[AW+31:32], e[31:0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // driver: compute expected words (R1 R2 R3 R4 R5 R6 R9), push, launch
  task automatic send(input logic [7:0] typ, input logic [7:0] ver, input int len,
                      input logic [AW-1:0] base, input bit inject, input string req);
    logic [7:0] pb [MAX_LEN+7];
    logic [7:0] s;
    int nsp, busy_cnt;
    cur_req = req;
    s = typ + ver + 8'(len - 1);
    for (int i = 1; i < len; i++) s = s + body[i];
    for (int i = 0; i < MAX_LEN + 7; i++) pb[i] = 8'h00;
    pb[0] = 8'h00 - s;
    for (int i = 1; i < len; i++) pb[i] = body[i];
    nsp = (len + 6) / 7;
    if (typ == AUD) nsp = 1;
    exp_q.push_back({base, 8'h00, 8'(len - 1), ver, typ});
    for (int k = 0; k < nsp; k++) begin
      exp_q.push_back({AW'(base + AW'(1 + 2*k)),
                       pb[7*k+3], pb[7*k+2], pb[7*k+1], pb[7*k]});
      exp_q.push_back({AW'(base + AW'(2 + 2*k)),
                       8'h00, pb[7*k+6], pb[7*k+5], pb[7*k+4]});
    end
    @(negedge clk);
    frm_type_i = typ; frm_ver_i = ver; frm_len_i = LW'(len); base_idx_i = base;
    for (int i = 1; i < MAX_LEN; i++) frm_body_i[(i-1)*8 +: 8] = body[i];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy_cnt = 0;
    while (busy_o) begin
      busy_cnt++;
      if (inject && busy_cnt == 2) begin
        start_i = 1'b1; frm_type_i = 8'h11; base_idx_i = 8'h00;
        for (int i = 1; i < MAX_LEN; i++) frm_body_i[(i-1)*8 +: 8] = 8'h5A;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(busy_cnt == 1 + 2*nsp, "R7 R9 busy cycles", busy_cnt, 1 + 2*nsp);
    check(exp_q.size() == 0, "R9 words left unwritten", exp_q.size(), 0);
    repeat (2) @(negedge clk);
    check(!busy_o && !wr_valid_o, "R7 idle after packet", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !wr_valid_o, "R7 reset state", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < MAX_LEN; i++) body[i] = 8'(i * 17 + 3);
    body[0] = 8'hEE; // never used: byte 0 is generated
    send(8'h82, 8'h02, 14, 8'h10, 0, "R1 R3");
    send(8'h81, 8'h01, 1, 8'h20, 0, "R4 lone checksum");
    send(8'h81, 8'h01, 7, 8'h30, 0, "R9 exact subpacket");
    send(8'h83, 8'h01, 8, 8'h40, 0, "R4 R9 one byte spill");
    send(8'h85, 8'h03, 20, 8'h50, 0, "R4 partial last");
    for (int i = 0; i < MAX_LEN; i++) body[i] = 8'hFF;
    send(8'h82, 8'hFF, 28, 8'hF8, 0, "R1 R5 wrap");
    for (int i = 0; i < MAX_LEN; i++) body[i] = 8'(200 - i * 5);
    send(AUD, 8'h01, 11, 8'h60, 0, "R6 audio");
    send(8'h82, 8'h02, 21, 8'h70, 1, "R7 start ignored");
    send(8'h82, 8'h02, 2, 8'h00, 0, "R2 R8 back to back");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule